// File: doc/BRIEF.md
# Draw Predication Control Unit

This unit holds the draw-predication state of a command processor: a global enable, a local enable and a latched predicate result. The command decoder presents one already-classified command per cycle. The unit handles three command kinds: set the global enable, set the local enable, and set the predicate.

A predicate-set command names its source and its test polarity inside the command word. When the source selects memory, the unit reads a 64-bit value over a simple request/response port and tests it. Any other source latches a passing predicate at once.

For each draw request the unit returns an execute-or-skip decision one cycle later. While a memory read is in flight, the unit stalls both commands and draws.

Top module: `draw_pred_unit`

## Requirements
- R1: After reset both enables are 0, no predicate is latched, `ready` is 1 and `rd_req` is 0, so a draw executes.
- R2: A global-enable command (`cmd_kind`=0) with `cmd_word[0]`=1 sets the global enable, sets the local enable to 1 and makes the latched predicate passing.
- R3: A global-enable command with `cmd_word[0]`=0 clears only the global enable, so draws execute regardless of the predicate.
- R4: A local-enable command (`cmd_kind`=1) sets the local enable to `cmd_word[0]` and leaves the global enable and the predicate unchanged.
- R5: A draw is skipped only when the global enable is set, the local enable is set, a predicate has been latched and that predicate fails. Every other draw executes.
- R6: In a predicate-set command (`cmd_kind`=2), source select is `cmd_word[7:4]` and polarity is `cmd_word[8]`. Source 5 raises `rd_req` in the next cycle with `rd_addr` = {`cmd_arg_hi`,`cmd_arg_lo`}.
- R7: Polarity 0 passes when the 64-bit response is nonzero. Polarity 1 passes when the response equals zero. All 64 bits take part in the test.
- R8: A predicate-set command with any source other than 5 latches a passing predicate and makes no read.
- R9: From acceptance of a memory predicate until its response, `ready` is 0 and no draw or command is accepted.
- R10: Command kind 3 is ignored. A read response that arrives while no read is outstanding is ignored.
- R11: An accepted draw (`draw_valid` and `ready`) yields `dec_valid` for exactly one cycle in the next cycle, with `dec_skip` giving the decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_kind | input | 2 | 0 global enable, 1 local enable, 2 predicate set, 3 none |
| cmd_word | input | 32 | Command word: enable value in bit 0, source in 7:4, polarity in 8 |
| cmd_arg_lo | input | 32 | Low word of the predicate address |
| cmd_arg_hi | input | 32 | High word of the predicate address |
| ready | output | 1 | Unit accepts commands and draws |
| rd_req | output | 1 | Memory read outstanding |
| rd_addr | output | 64 | Read address |
| rd_resp_valid | input | 1 | Read data returned |
| rd_resp_data | input | 64 | Read data |
| draw_valid | input | 1 | Draw request |
| dec_valid | output | 1 | Decision strobe |
| dec_skip | output | 1 | 1 skip, 0 execute |

## Verification
The decision is swept over every combination of global enable, local enable and predicate state (none, passing, failing). This sweep separates the three-way condition from any partial one.

Memory predicates are tried with both polarities against zero, one, the top bit alone, a bit in the upper word and all ones. These values separate a full 64-bit test from a truncated one and separate the two polarities. Every source code other than 5 is tried to show that it never starts a read.

Ordered command sequences show that the global enable resets the local enable and the predicate, while the local enable disturbs nothing. Stalled draws, idle responses and kind-3 commands confirm that these inputs have no effect.

// File: rtl/draw_pred_unit.sv
module draw_pred_unit #(
  parameter int CW      = 32,
  parameter int SRC_MEM = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [1:0]    cmd_kind,
  input  logic [CW-1:0] cmd_word,
  input  logic [31:0]   cmd_arg_lo,
  input  logic [31:0]   cmd_arg_hi,
  output logic          ready,
  output logic          rd_req,
  output logic [63:0]   rd_addr,
  input  logic          rd_resp_valid,
  input  logic [63:0]   rd_resp_data,
  input  logic          draw_valid,
  output logic          dec_valid,
  output logic          dec_skip
);
  localparam logic [1:0] K_GLOBAL = 2'd0;
  localparam logic [1:0] K_LOCAL  = 2'd1;
  localparam logic [1:0] K_PRED   = 2'd2;

  logic glob_en, loc_en, pred_set, pred_pass, busy, pol_q;
  logic [63:0] addr_q;

  wire       cmd_go    = cmd_valid && ready;
  wire [3:0] src       = cmd_word[7:4];
  wire       pol       = cmd_word[8];
  wire       resp_pass = pol_q ? (rd_resp_data == 64'd0) : (rd_resp_data != 64'd0);
  wire       applies   = glob_en && loc_en && pred_set;

  assign ready   = !busy;
  assign rd_req  = busy;
  assign rd_addr = addr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      glob_en   <= 1'b0;
      loc_en    <= 1'b0;
      pred_set  <= 1'b0;
      pred_pass <= 1'b0;
      busy      <= 1'b0;
      pol_q     <= 1'b0;
      addr_q    <= '0;
      dec_valid <= 1'b0;
      dec_skip  <= 1'b0;
    end else begin
      dec_valid <= draw_valid && ready;
      dec_skip  <= draw_valid && ready && applies && !pred_pass;
      if (busy && rd_resp_valid) begin
        pred_set  <= 1'b1;
        pred_pass <= resp_pass;
        busy      <= 1'b0;
      end
      if (cmd_go) begin
        case (cmd_kind)
          K_GLOBAL: begin
            glob_en <= cmd_word[0];
            if (cmd_word[0]) begin
              loc_en    <= 1'b1;
              pred_pass <= 1'b1;
            end
          end
          K_LOCAL: loc_en <= cmd_word[0];
          K_PRED: begin
            if (src == 4'(SRC_MEM)) begin
              busy   <= 1'b1;
              pol_q  <= pol;
              addr_q <= {cmd_arg_hi, cmd_arg_lo};
            end else begin
              pred_set  <= 1'b1;
              pred_pass <= 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/draw_pred_chk.sv
module draw_pred_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_valid,
  input logic [1:0]  cmd_kind,
  input logic [31:0] cmd_word,
  input logic [31:0] cmd_arg_lo,
  input logic [31:0] cmd_arg_hi,
  input logic        ready,
  input logic        rd_req,
  input logic [63:0] rd_addr,
  input logic        draw_valid,
  input logic        dec_valid,
  input logic        dec_skip
);
  wire pred_go = cmd_valid && ready && cmd_kind == 2'd2;

  assert_mem_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pred_go && cmd_word[7:4] == 4'd5 |=> rd_req && rd_addr == {$past(cmd_arg_hi), $past(cmd_arg_lo)});

  assert_no_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pred_go && cmd_word[7:4] != 4'd5 && !rd_req |=> !rd_req);

  assert_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |=> !dec_valid);

  assert_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && ready && cmd_kind == 2'd3 |=> !rd_req);

  assert_dec_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> $past(draw_valid && ready));

  assert_skip_qual_R11: assert property (@(posedge clk) disable iff (!rst_n)
    dec_skip |-> dec_valid);
endmodule

bind draw_pred_unit draw_pred_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
  .cmd_word(cmd_word), .cmd_arg_lo(cmd_arg_lo), .cmd_arg_hi(cmd_arg_hi),
  .ready(ready), .rd_req(rd_req), .rd_addr(rd_addr), .draw_valid(draw_valid),
  .dec_valid(dec_valid), .dec_skip(dec_skip)
);

// File: tb/tb_draw_pred_unit.sv
`timescale 1ns/1ps
module tb_draw_pred_unit;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, draw_valid = 1'b0, rd_resp_valid = 1'b0;
  logic [1:0] cmd_kind = 2'd3;
  logic [31:0] cmd_word = '0, cmd_arg_lo = '0, cmd_arg_hi = '0;
  logic [63:0] rd_resp_data = '0;
  logic ready, rd_req, dec_valid, dec_skip;
  logic [63:0] rd_addr;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  draw_pred_unit dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
    .cmd_word(cmd_word), .cmd_arg_lo(cmd_arg_lo), .cmd_arg_hi(cmd_arg_hi),
    .ready(ready), .rd_req(rd_req), .rd_addr(rd_addr),
    .rd_resp_valid(rd_resp_valid), .rd_resp_data(rd_resp_data),
    .draw_valid(draw_valid), .dec_valid(dec_valid), .dec_skip(dec_skip)
  );

  task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic send(logic [1:0] k, logic [31:0] w, logic [63:0] a);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_kind = k; cmd_word = w;
    cmd_arg_lo = a[31:0]; cmd_arg_hi = a[63:32];
    @(negedge clk);
    cmd_valid = 1'b0; cmd_kind = 2'd3;
  endtask

  task automatic draw(bit exp_skip, string tag);
    @(negedge clk); draw_valid = 1'b1;
    @(negedge clk); draw_valid = 1'b0;
    check(dec_valid === 1'b1, {tag, " R11 strobe"}, 64'(dec_valid), 64'd1);
    check(dec_skip === exp_skip, tag, 64'(dec_skip), 64'(exp_skip));
    @(negedge clk);
    check(dec_valid === 1'b0, "R11 one-cycle", 64'(dec_valid), 64'd0);
  endtask

  task automatic pred_local(logic [3:0] src, bit pol);
    send(2'd2, {23'd0, pol, src, 4'd0}, 64'd0);
    check(rd_req === 1'b0, "R8 no read", 64'(rd_req), 64'd0);
  endtask

  task automatic pred_mem(bit pol, logic [63:0] data, logic [63:0] addr, int lat);
    send(2'd2, {23'd0, pol, 4'd5, 4'd0}, addr);
    check(rd_req === 1'b1, "R6 request", 64'(rd_req), 64'd1);
    check(rd_addr === addr, "R6 address", rd_addr, addr);
    draw_valid = 1'b1;
    for (int i = 0; i < lat; i++) begin
      @(negedge clk);
      check(ready === 1'b0, "R9 ready low", 64'(ready), 64'd0);
      check(dec_valid === 1'b0, "R9 draw stalled", 64'(dec_valid), 64'd0);
    end
    draw_valid = 1'b0;
    rd_resp_valid = 1'b1; rd_resp_data = data;
    @(negedge clk);
    rd_resp_valid = 1'b0;
    check(ready === 1'b1 && rd_req === 1'b0, "R9 released", 64'(ready), 64'd1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [63:0] pats [5];
    pats[0] = 64'd0; pats[1] = 64'd1; pats[2] = 64'h8000_0000_0000_0000;
    pats[3] = 64'h0000_0001_0000_0000; pats[4] = '1;

    do_reset();
    @(negedge clk);
    check(ready === 1'b1, "R1 ready", 64'(ready), 64'd1);
    check(rd_req === 1'b0, "R1 rd_req", 64'(rd_req), 64'd0);
    check(dec_valid === 1'b0, "R1 dec_valid", 64'(dec_valid), 64'd0);
    draw(1'b0, "R1 draw after reset");

    // R5: sweep global x local x predicate (0 none, 1 pass, 2 fail)
    for (int g = 0; g < 2; g++)
      for (int l = 0; l < 2; l++)
        for (int p = 0; p < 3; p++) begin
          do_reset();
          if (g == 1) send(2'd0, 32'd1, 64'd0);
          send(2'd1, 32'(l), 64'd0);
          if (p == 1) pred_local(4'd0, 1'b0);
          if (p == 2) pred_mem(1'b0, 64'd0, 64'h1234_5678_9abc_def0 + 64'(p), 1);
          draw(g == 1 && l == 1 && p == 2, $sformatf("R5 g%0d l%0d p%0d", g, l, p));
        end

    // R7: polarity x pattern
    for (int pol = 0; pol < 2; pol++)
      for (int d = 0; d < 5; d++) begin
        bit pass;
        do_reset();
        send(2'd0, 32'd1, 64'd0);
        pred_mem(pol[0], pats[d], {32'(d), 32'hA000_0000 + 32'(pol)}, 1 + d % 3);
        pass = pol ? (pats[d] == 0) : (pats[d] != 0);
        draw(!pass, $sformatf("R7 pol%0d pat%0d", pol, d));
      end

    // R8: every non-memory source latches pass
    for (int s = 0; s < 16; s++)
      for (int pol = 0; pol < 2; pol++) begin
        if (s == 5) continue;
        do_reset();
        send(2'd0, 32'd1, 64'd0);
        pred_mem(1'b0, 64'd0, 64'h40, 1);
        pred_local(4'(s), pol[0]);
        draw(1'b0, $sformatf("R8 src%0d pol%0d", s, pol));
      end

    // R2: global enable resets predicate and local enable
    do_reset();
    send(2'd0, 32'd1, 64'd0);
    pred_mem(1'b1, 64'd9, 64'h80, 2);
    draw(1'b1, "R2 setup fail");
    send(2'd0, 32'd1, 64'd0);
    draw(1'b0, "R2 predicate reset to pass");
    send(2'd1, 32'd0, 64'd0);
    send(2'd0, 32'd1, 64'd0);
    pred_mem(1'b0, 64'd0, 64'h88, 1);
    draw(1'b1, "R2 local forced to 1");

    // R3 and R4
    send(2'd1, 32'd0, 64'd0);
    draw(1'b0, "R4 local off");
    send(2'd1, 32'd1, 64'd0);
    draw(1'b1, "R4 local on keeps predicate");
    send(2'd0, 32'd0, 64'd0);
    draw(1'b0, "R3 global off");
    send(2'd1, 32'd1, 64'd0);
    draw(1'b0, "R3 global stays off");

    // R10: kind 3 and idle responses ignored
    do_reset();
    send(2'd0, 32'd1, 64'd0);
    pred_mem(1'b0, 64'd0, 64'hC0, 1);
    send(2'd3, 32'h0000_0150, 64'h10);
    check(rd_req === 1'b0, "R10 kind3 no read", 64'(rd_req), 64'd0);
    draw(1'b1, "R10 kind3 ignored");
    @(negedge clk); rd_resp_valid = 1'b1; rd_resp_data = 64'd7;
    @(negedge clk); rd_resp_valid = 1'b0;
    draw(1'b1, "R10 idle response ignored");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule